// File: doc/BRIEF.md
# Trace Capture Control and Store Qualifier

This block sits inside an on-chip debug unit. It holds an 8-bit trace control word and, on every bus cycle, decides whether the observed bus event becomes a trace entry. Events come from two bus masters: a main CPU (master 0) and a coprocessor (master 1). Each event carries an address, data, an access flag, a change-of-flow flag and two range-comparator hit flags. A separate input says whether the range comparator watches the coprocessor bus.

The control word selects which masters are traced and the trace mode. It also selects an address-range filter for detailed CPU tracing, and holds a trigger-alignment code. That code is only exported for a separate alignment counter. Writes to the word are blocked according to the secured and armed status. A secured system never stores entries and cannot trace.

When an event qualifies, the block presents a store strobe together with the entry contents to the trace memory one clock later.

Top module: `trc_ctl_qual`

## Requirements
- R1: After reset the control word reads 0x00, `trig_align` is 0 and `st_valid` is low.
- R2: The source field (bits 7:6) takes a written value only when the write occurs while both `secured` and `armed` are low.
- R3: Bits 5:0 take a written value only when the write occurs while `armed` is low. `cfg_rdata` always shows the stored word, and a write becomes visible on the next cycle.
- R4: While `secured` is high, the source field is cleared to 00 on the next clock, and no event presented in that cycle is stored.
- R5: An event is stored only while `armed` is high and the source field selects the event's master. The source encodings are 00 none, 01 CPU only, 10 coprocessor only and 11 both.
- R6: In mode 00 (bits 3:2), only events with the change-of-flow flag set are stored.
- R7: In mode 01, change-of-flow events are stored unless their address equals the address of the last stored entry. That memory is forgotten in the cycle in which `armed` rises.
- R8: In mode 10, every event with the access flag set is stored, subject to R9. With source 11, mode 10 stores nothing.
- R9: Range filtering uses bits 5:4 and applies only to CPU events in mode 10 with source 01. The encodings are 00 no filter, 01 requires `hit_c`, 10 requires `hit_d`, and 11 requires both flags.
- R10: The range field has no effect on coprocessor events, when the source is 10 or 11, or when `cmp_on_cop` is high.
- R11: Mode 11 stores nothing. `trig_align` always equals bits 1:0 of the control word.
- R12: A stored event appears on `st_valid` one clock after it was presented. `st_master`, `st_addr`, `st_data` and `st_cof` carry that event's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Control word readback |
| secured | input | 1 | System is secured |
| armed | input | 1 | Debug unit is armed |
| ev_valid | input | 1 | A bus event is presented this cycle |
| ev_master | input | 1 | Event master: 0 CPU, 1 coprocessor |
| ev_addr | input | ADDR_W | Event address or flow target |
| ev_data | input | DATA_W | Event data |
| ev_cof | input | 1 | Event is a change of flow |
| ev_acc | input | 1 | Event is a memory or register access |
| hit_c | input | 1 | Comparator C matched this event |
| hit_d | input | 1 | Comparator D matched this event |
| cmp_on_cop | input | 1 | Range comparator watches the coprocessor bus |
| st_valid | output | 1 | Store this entry |
| st_master | output | 1 | Entry master |
| st_addr | output | ADDR_W | Entry address |
| st_data | output | DATA_W | Entry data |
| st_cof | output | 1 | Entry change-of-flow flag |
| trig_align | output | 2 | Trigger alignment code for the alignment counter |

## Verification
The bench attempts control writes while armed and while secured. A design with loose locks would let the word change mid-session, and one with a weak security gate would keep a non-zero source or store an entry. Loop mode is driven with a small address space so that repeats are frequent, and the bench re-arms in the middle of the run. A design that compared against a stale address after arming would drop a legitimate first entry. Detailed tracing is exercised for every source value, every range code, with both masters and with the comparator steered to the coprocessor bus. Errors such as filtering coprocessor traffic, or storing in the both-masters detail case, would show up as surplus or missing strobes.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'b00,
      SRC_CPU  = 2'b01,
      SRC_COP  = 2'b10,
      SRC_BOTH = 2'b11
   } trc_src_e;

   typedef enum logic [1:0] {
      RNG_ALL  = 2'b00,
      RNG_C    = 2'b01,
      RNG_D    = 2'b10,
      RNG_CD   = 2'b11
   } trc_rng_e;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_LOOP   = 2'b01,
      MODE_DETAIL = 2'b10,
      MODE_RSVD   = 2'b11
   } trc_mode_e;

   // Field order is fixed: the word is read back as a whole.
   typedef struct packed {
      trc_src_e  src;
      trc_rng_e  rng;
      trc_mode_e mode;
      logic [1:0] align;
   } trc_cfg_t;

   localparam int unsigned CFG_W = $bits(trc_cfg_t);

endpackage

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg
   import trc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  logic [CFG_W-1:0] wdata,
   input  logic     secured,
   input  logic     armed,
   output trc_cfg_t cfg
);

   trc_cfg_t cfg_q;
   trc_cfg_t wr_word;
   logic     low_open;
   logic     src_open;

   assign wr_word  = trc_cfg_t'(wdata);
   assign low_open = we && !armed;
   assign src_open = low_open && !secured;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (secured) begin
            cfg_q.src <= SRC_NONE;
         end else if (src_open) begin
            cfg_q.src <= wr_word.src;
         end
         if (low_open) begin
            cfg_q.rng   <= wr_word.rng;
            cfg_q.mode  <= wr_word.mode;
            cfg_q.align <= wr_word.align;
         end
      end
   end

   assign cfg = cfg_q;

   p_src_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !secured) |=> $stable(cfg_q.src));

   p_low_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> ($stable(cfg_q.rng) && $stable(cfg_q.mode) && $stable(cfg_q.align)));

   p_sec_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      secured |=> (cfg_q.src == SRC_NONE));

endmodule

// File: rtl/trc_loop_mem.sv
module trc_loop_mem #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              store,
   input  logic [ADDR_W-1:0] addr,
   output logic              redundant
);

   logic              armed_q;
   logic              last_vld;
   logic [ADDR_W-1:0] last_addr;
   logic              arm_rise;

   assign arm_rise  = armed && !armed_q;
   assign redundant = last_vld && !arm_rise && (addr == last_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         last_vld  <= 1'b0;
         last_addr <= '0;
      end else begin
         armed_q <= armed;
         if (store) begin
            last_vld  <= 1'b1;
            last_addr <= addr;
         end else if (arm_rise) begin
            last_vld  <= 1'b0;
         end
      end
   end

   p_arm_forget_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !armed_q && !store) |=> !last_vld);

   p_track_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> (last_vld && last_addr == $past(addr)));

endmodule

// File: rtl/trc_qualify.sv
module trc_qualify
   import trc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  trc_src_e  src,
   input  trc_rng_e  rng,
   input  trc_mode_e mode,
   input  logic      secured,
   input  logic      armed,
   input  logic      ev_valid,
   input  logic      ev_master,
   input  logic      ev_cof,
   input  logic      ev_acc,
   input  logic      hit_c,
   input  logic      hit_d,
   input  logic      cmp_on_cop,
   input  logic      redundant,
   output logic      store
);

   logic master_on;
   logic narrow;
   logic rng_ok;
   logic mode_ok;

   assign master_on = ev_master ? src[1] : src[0];
   assign narrow    = (src == SRC_CPU) && !ev_master && !cmp_on_cop;

   always_comb begin
      rng_ok = 1'b1;
      if (narrow) begin
         unique case (rng)
            RNG_ALL: rng_ok = 1'b1;
            RNG_C:   rng_ok = hit_c;
            RNG_D:   rng_ok = hit_d;
            RNG_CD:  rng_ok = hit_c && hit_d;
            default: rng_ok = 1'b0;
         endcase
      end
   end

   always_comb begin
      unique case (mode)
         MODE_NORMAL: mode_ok = ev_cof;
         MODE_LOOP:   mode_ok = ev_cof && !redundant;
         MODE_DETAIL: mode_ok = ev_acc && (src != SRC_BOTH) && rng_ok;
         default:     mode_ok = 1'b0;
      endcase
   end

   assign store = ev_valid && armed && !secured && master_on && mode_ok;

   p_both_detail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_BOTH && mode == MODE_DETAIL) |-> !store);

   p_rsvd_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RSVD) |-> !store);

   p_cop_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && armed && !secured && ev_master && src == SRC_COP
       && mode == MODE_DETAIL && ev_acc) |-> store);

endmodule

// File: rtl/trc_ctl_qual.sv
module trc_ctl_qual
   import trc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              secured,
   input  logic              armed,
   input  logic              ev_valid,
   input  logic              ev_master,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] ev_data,
   input  logic              ev_cof,
   input  logic              ev_acc,
   input  logic              hit_c,
   input  logic              hit_d,
   input  logic              cmp_on_cop,
   output logic              st_valid,
   output logic              st_master,
   output logic [ADDR_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data,
   output logic              st_cof,
   output logic [1:0]        trig_align
);

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
         $error("trc_ctl_qual: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("trc_ctl_qual: DATA_W out of range");
      end
      if (CFG_W != 8) begin : g_bad_cfg
         $error("trc_ctl_qual: control word must be 8 bits");
      end
   endgenerate

   trc_cfg_t cfg;
   logic     redundant;
   logic     store;

   trc_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .secured (secured),
      .armed   (armed),
      .cfg     (cfg)
   );

   trc_loop_mem #(.ADDR_W(ADDR_W)) u_loop (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .store     (store),
      .addr      (ev_addr),
      .redundant (redundant)
   );

   trc_qualify u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (cfg.src),
      .rng        (cfg.rng),
      .mode       (cfg.mode),
      .secured    (secured),
      .armed      (armed),
      .ev_valid   (ev_valid),
      .ev_master  (ev_master),
      .ev_cof     (ev_cof),
      .ev_acc     (ev_acc),
      .hit_c      (hit_c),
      .hit_d      (hit_d),
      .cmp_on_cop (cmp_on_cop),
      .redundant  (redundant),
      .store      (store)
   );

   assign cfg_rdata  = cfg;
   assign trig_align = cfg.align;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_valid  <= 1'b0;
               st_master <= 1'b0;
               st_addr   <= '0;
               st_data   <= '0;
               st_cof    <= 1'b0;
            end else begin
               st_valid <= store;
               if (store) begin
                  st_master <= ev_master;
                  st_addr   <= ev_addr;
                  st_data   <= ev_data;
                  st_cof    <= ev_cof;
               end
            end
         end

         p_secure_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            secured |=> !st_valid);

         p_unarmed_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !armed |=> !st_valid);

         p_entry_copy_r12: assert property (@(posedge clk) disable iff (!rst_n)
            store |=> (st_valid && st_addr == $past(ev_addr)
                       && st_master == $past(ev_master)));
      end else begin : g_out_comb
         assign st_valid  = store;
         assign st_master = ev_master;
         assign st_addr   = ev_addr;
         assign st_data   = ev_data;
         assign st_cof    = ev_cof;

         p_secure_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            secured |-> !st_valid);
      end
   endgenerate

endmodule

// File: tb/trc_ctl_qual_tb_top.sv
`timescale 1ns/1ps
module trc_ctl_qual_tb_top;

   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic          secured = 1'b0;
   logic          armed = 1'b0;
   logic          ev_valid = 1'b0;
   logic          ev_master = 1'b0;
   logic [AW-1:0] ev_addr = '0;
   logic [DW-1:0] ev_data = '0;
   logic          ev_cof = 1'b0;
   logic          ev_acc = 1'b0;
   logic          hit_c = 1'b0;
   logic          hit_d = 1'b0;
   logic          cmp_on_cop = 1'b0;
   logic          st_valid;
   logic          st_master;
   logic [AW-1:0] st_addr;
   logic [DW-1:0] st_data;
   logic          st_cof;
   logic [1:0]    trig_align;

   always #2 clk = ~clk;

   trc_ctl_qual #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .secured(secured), .armed(armed),
      .ev_valid(ev_valid), .ev_master(ev_master), .ev_addr(ev_addr),
      .ev_data(ev_data), .ev_cof(ev_cof), .ev_acc(ev_acc), .hit_c(hit_c),
      .hit_d(hit_d), .cmp_on_cop(cmp_on_cop), .st_valid(st_valid),
      .st_master(st_master), .st_addr(st_addr), .st_data(st_data),
      .st_cof(st_cof), .trig_align(trig_align)
   );

   // Behavioural reference: state held as plain variables.
   logic [7:0]    m_cfg;
   logic [AW-1:0] m_last;
   bit            m_have_last;
   bit            m_arm_prev;
   bit            e_valid;
   logic          e_master;
   logic [AW-1:0] e_addr;
   logic [DW-1:0] e_data;
   logic          e_cof;

   function automatic bit decide(logic [7:0] c);
      bit src_hit, ok, rise;
      int src, rng, mode;
      src  = int'(c[7:6]);
      rng  = int'(c[5:4]);
      mode = int'(c[3:2]);
      rise = armed && !m_arm_prev;
      if (!ev_valid || !armed || secured) return 0;
      src_hit = (ev_master == 1'b0) ? (src == 1 || src == 3) : (src == 2 || src == 3);
      if (!src_hit) return 0;
      case (mode)
         0: ok = ev_cof;
         1: ok = ev_cof && !(m_have_last && !rise && ev_addr == m_last);
         2: begin
            if (src == 3) ok = 0;
            else if (!ev_acc) ok = 0;
            else if (src == 1 && !ev_master && !cmp_on_cop)
               ok = (rng == 0) || (rng == 1 && hit_c) || (rng == 2 && hit_d)
                    || (rng == 3 && hit_c && hit_d);
            else ok = 1;
         end
         default: ok = 0;
      endcase
      return ok;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg = '0; m_last = '0; m_have_last = 0; m_arm_prev = 0;
         e_valid = 0; e_master = 0; e_addr = '0; e_data = '0; e_cof = 0;
      end else begin
         bit s;
         s = decide(m_cfg);
         e_valid = s;
         if (s) begin
            e_master = ev_master; e_addr = ev_addr; e_data = ev_data; e_cof = ev_cof;
            m_last = ev_addr; m_have_last = 1;
         end else if (armed && !m_arm_prev) begin
            m_have_last = 0;
         end
         if (secured) m_cfg[7:6] = 2'b00;
         else if (cfg_we && !armed) m_cfg[7:6] = cfg_wdata[7:6];
         if (cfg_we && !armed) m_cfg[5:0] = cfg_wdata[5:0];
         m_arm_prev = armed;
      end
   end

   int    n_chk = 0;
   int    n_fail = 0;
   int    n_store = 0;
   string cur_req = "R1";

   task automatic fail_line(string what, longint act, longint exp);
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
   endtask

   task automatic compare();
      bit bad;
      bad = 0;
      n_chk++;
      if (cfg_rdata !== m_cfg) begin fail_line("cfg_rdata", cfg_rdata, m_cfg); bad = 1; end
      if (!bad && trig_align !== m_cfg[1:0]) begin fail_line("trig_align", trig_align, m_cfg[1:0]); bad = 1; end
      if (!bad && st_valid !== e_valid) begin fail_line("st_valid", st_valid, e_valid); bad = 1; end
      if (!bad && e_valid) begin
         n_store++;
         if (st_addr !== e_addr) fail_line("st_addr", st_addr, e_addr);
         else if (st_data !== e_data) fail_line("st_data", st_data, e_data);
         else if (st_master !== e_master) fail_line("st_master", st_master, e_master);
         else if (st_cof !== e_cof) fail_line("st_cof", st_cof, e_cof);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_ev();
      ev_valid = 0; ev_cof = 0; ev_acc = 0; hit_c = 0; hit_d = 0;
   endtask

   task automatic cfg_set(logic [7:0] v);
      idle_ev();
      armed = 0; cyc();
      cfg_we = 1; cfg_wdata = v; cyc();
      cfg_we = 0; armed = 1; cyc();
   endtask

   task automatic rnd_events(int n, int amask, int master_mode);
      for (int i = 0; i < n; i++) begin
         ev_valid  = ($urandom_range(3) != 0);
         ev_master = (master_mode == 2) ? 1'($urandom_range(1)) : 1'(master_mode);
         ev_addr   = AW'($urandom & amask);
         ev_data   = DW'($urandom);
         ev_cof    = 1'($urandom_range(1));
         ev_acc    = 1'($urandom_range(1));
         hit_c     = 1'($urandom_range(1));
         hit_d     = 1'($urandom_range(1));
         cyc();
      end
      idle_ev();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      // R1: reset state
      #1;
      n_chk++;
      if (cfg_rdata !== 8'h00 || st_valid !== 1'b0 || trig_align !== 2'b00)
         fail_line("reset outputs", {cfg_rdata, 1'(st_valid)}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc(); cyc();

      // R3: writes while disarmed land in full; then armed writes rejected
      cur_req = "R3";
      cfg_we = 1; cfg_wdata = 8'hA5; cyc();
      cfg_we = 0; cyc();
      cur_req = "R2";
      armed = 1; cyc();
      cfg_we = 1; cfg_wdata = 8'h5A; cyc(); cyc();
      cfg_we = 0; cyc();
      cur_req = "R3";
      armed = 0; cfg_we = 1; cfg_wdata = 8'h3C; cyc();
      cfg_we = 0; cyc();

      // R2/R4: secured blocks source writes and clears source
      cur_req = "R4";
      cfg_we = 1; cfg_wdata = 8'h40; cyc();
      cfg_we = 0; secured = 1; cyc(); cyc();
      cfg_we = 1; cfg_wdata = 8'hC7; cyc();
      cfg_we = 0; cyc();
      secured = 0;
      cfg_set(8'hC0);
      secured = 1; rnd_events(30, 16'hFFFF, 2);
      secured = 0; cyc();

      // R5: source selection under normal mode
      cur_req = "R5";
      for (int s = 0; s < 4; s++) begin
         cfg_set(8'(s << 6));
         rnd_events(40, 16'hFFFF, 2);
         armed = 0; rnd_events(10, 16'hFFFF, 2); armed = 1;
      end

      // R6/R12: normal mode, change-of-flow only, entry contents
      cur_req = "R6/R12";
      cfg_set(8'hC2);
      rnd_events(80, 16'hFFFF, 2);

      // R7: loop mode redundancy with a tiny address space, re-arm midway
      cur_req = "R7";
      cfg_set(8'hC4);
      rnd_events(60, 3, 2);
      armed = 0; cyc(); armed = 1;
      ev_valid = 1; ev_master = 0; ev_cof = 1; ev_addr = st_addr; ev_data = 16'h1234; cyc();
      idle_ev();
      rnd_events(60, 1, 0);
      cfg_set(8'h44);
      rnd_events(40, 3, 2);

      // R8: detail mode for each source
      cur_req = "R8";
      for (int s = 1; s < 4; s++) begin
         cfg_set(8'((s << 6) | 8'h08));
         rnd_events(50, 16'hFFFF, 2);
      end

      // R9: range codes on CPU detail tracing
      cur_req = "R9";
      for (int r = 0; r < 4; r++) begin
         cfg_set(8'(8'h48 | (r << 4)));
         rnd_events(50, 16'hFFFF, 0);
      end

      // R10: range ignored for coprocessor, both, or comparator steered away
      cur_req = "R10";
      cfg_set(8'hB8);
      rnd_events(50, 16'hFFFF, 2);
      cfg_set(8'h78);
      cmp_on_cop = 1; rnd_events(50, 16'hFFFF, 0);
      cmp_on_cop = 0; rnd_events(30, 16'hFFFF, 0);

      // R11: reserved mode and alignment export
      cur_req = "R11";
      for (int a = 0; a < 4; a++) begin
         cfg_set(8'(8'hCC | a));
         rnd_events(30, 16'hFFFF, 2);
      end

      cur_req = "R12";
      n_chk++;
      if (n_store < 50) fail_line("store count too low", n_store, 50);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule